// File: doc/BRIEF.md
# Message-Based SPI Master

This block is a single-master SPI controller. It sits behind a small register window on a plain synchronous write/combinational-read bus. Software first fills an eight-byte transmit buffer. It then writes a control word that holds the byte count and the message type. Last, it writes a start command that carries a device number. The engine then asserts that device's chip select. It shifts the whole message out MSB first in 8-bit words, stores incoming bits into an eight-byte receive buffer, and releases the select. At that point it records how many bytes were captured and sets a done flag, which can raise an interrupt.

A configuration register sets the SPI mode with separate clock-polarity and clock-phase bits. The same register holds a three-bit rate code that picks one of seven serial clock rates, each a power-of-two division of the system clock. Every bit of that register is stored and read back, so software may read-modify-write the rate field without disturbing the other bits.

Register map (word addresses): 0 message control, 1 command (write only), 2 interrupt status, 3 interrupt mask, 4 configuration, 5 receive tail, 6 busy, 8 to 15 data window (write = transmit byte slot, read = receive byte slot).

Top module: `spi_msg_master`

## Requirements
- R1: After reset, all chip selects are high, sck, mosi and irq are 0, and the status, tail, busy, mask and configuration registers read 0.
- R2: The configuration register reads back every written bit. Bits [2:0] hold the rate code, bit 4 is the clock phase and bit 5 is the clock polarity. The half period of sck is BASE_HALF << (6 - code) system clocks for codes 0 to 6, so code 0 is the slowest. Code 7 behaves like code 6.
- R3: A write to the command register with opcode bits [3:0] = 2 starts a message. It drives low only cs_n[bits 9:8 of the command]. Any other opcode is ignored, and a start with a byte count of 0 is ignored.
- R4: Chip select stays low for half x (16n + 1) system clocks for an n-byte message. The first sck edge comes one half period after chip select falls, and the last edge comes one half period before it rises.
- R5: In every one of the four modes, sck idles at the polarity bit and bytes go out MSB first. With phase 0 data is sampled on the leading edge; with phase 1 it is sampled on the trailing edge.
- R6: Message control holds the count in bits [3:0] and the type in bits [9:8]. In full duplex (type 0, or the reserved type 3), the n transmit bytes reach the slave and the n bytes from the slave land in receive slots 0 to n-1. The tail then reads n.
- R7: In half-duplex write (type 1), the transmit bytes reach the slave, the receive buffer is left unchanged and the tail reads 0.
- R8: In half-duplex read (type 2), mosi is held low for the whole message, the received bytes are stored and the tail reads n.
- R9: The done flag (status bit 0) sets only when chip select rises at the end of a message. irq equals done AND mask bit 0. Writing 1 to status bit 0 clears done.
- R10: A start command issued while busy is ignored: the select, the device and the length of the running message are unchanged.
- R11: A count field above 8 is handled as 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| irq | output | 1 | Done interrupt |

## Verification
Register reads are combinational, so every read is taken one nanosecond after a falling clock edge in the same cycle the address is applied. A start written at rising edge P0 pulls the select low at P0. The first sck edge is due at P0 + half, and the select rises at P0 + half x (16n + 1). The done flag and the tail settle at that same edge. The bench counts falling edges from the one right after P0, so the select window and the first-edge offset are compared against those exact products. Each result is read only after the select has returned high. A loopback slave model, written apart from the design, follows the mode rules, and its captured bytes and returned bytes give the expected values for every mode, type and length from 1 to 8.

// File: rtl/spi_msg_master.sv
module spi_msg_master #(
  parameter int DEPTH     = 8,
  parameter int NCS       = 4,
  parameter int BASE_HALF = 1,
  localparam int AW       = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [15:0]    bus_wdata,
  output logic [15:0]    bus_rdata,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n,
  output logic           irq
);
  localparam int BW = $clog2(DEPTH);
  localparam int CW = BW + 1;
  localparam int IW = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int NB = 8 * DEPTH;
  localparam int XW = $clog2(NB);
  localparam int EW = XW + 1;
  localparam int HW = $clog2(BASE_HALF * 64 + 1);
  localparam logic [1:0] T_WR = 2'd1;
  localparam logic [1:0] T_RD = 2'd2;
  localparam logic [3:0] OP_GO = 4'h2;

  logic [15:0]   cfg_q;
  logic [CW-1:0] cnt_q, n_q, tail_q;
  logic [1:0]    typ_q, mt_q;
  logic          busy_q, trail_q, done_q, mask_q, sck_q, cpha_q;
  logic [HW-1:0] div_q, half_q;
  logic [EW-1:0] e_q;
  logic [XW-1:0] obit_q;
  logic [IW-1:0] id_q;
  logic [NB-1:0] tx_q, rx_q;

  wire           in_buf = bus_addr[AW-1];
  wire [BW-1:0]  slot   = bus_addr[BW-1:0];
  wire [2:0]     code   = cfg_q[2:0];
  wire [HW-1:0]  half_sel = HW'(BASE_HALF) << ((code == 3'd7) ? 3'd0 : 3'd6 - code);
  wire [CW-1:0]  n_eff  = (cnt_q > CW'(DEPTH)) ? CW'(DEPTH) : cnt_q;
  wire           cmd_wr = bus_we && !in_buf && bus_addr == AW'(1);
  wire           go     = cmd_wr && bus_wdata[3:0] == OP_GO && !busy_q && n_eff != '0;
  wire           tick   = div_q == half_q - 1'b1;
  wire [XW-1:0]  bi     = e_q[EW-1:1];
  wire [CW+3:0]  e_end  = {n_q, 4'b0000} - 1'b1;
  wire           last   = e_q == e_end[EW-1:0];
  wire           samp   = e_q[0] == cpha_q;

  assign sck  = sck_q;
  assign mosi = busy_q && mt_q != T_RD && tx_q[obit_q ^ XW'(7)];
  assign cs_n = busy_q ? ~(NCS'(1) << id_q) : '1;
  assign irq  = done_q & mask_q;

  always_comb begin
    bus_rdata = '0;
    if (in_buf) bus_rdata[7:0] = rx_q[{slot, 3'b000} +: 8];
    else begin
      case (bus_addr)
        AW'(0): begin bus_rdata[CW-1:0] = cnt_q; bus_rdata[9:8] = typ_q; end
        AW'(2): bus_rdata[0] = done_q;
        AW'(3): bus_rdata[0] = mask_q;
        AW'(4): bus_rdata = cfg_q;
        AW'(5): bus_rdata[CW-1:0] = tail_q;
        AW'(6): bus_rdata[0] = busy_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0; cnt_q <= '0; typ_q <= '0; n_q <= '0; tail_q <= '0; mt_q <= '0;
      busy_q <= 1'b0; trail_q <= 1'b0; done_q <= 1'b0; mask_q <= 1'b0;
      sck_q <= 1'b0; cpha_q <= 1'b0; div_q <= '0; half_q <= '0;
      e_q <= '0; obit_q <= '0; id_q <= '0; tx_q <= '0; rx_q <= '0;
    end else begin
      if (bus_we && !in_buf) begin
        case (bus_addr)
          AW'(0): begin cnt_q <= bus_wdata[CW-1:0]; typ_q <= bus_wdata[9:8]; end
          AW'(2): if (bus_wdata[0]) done_q <= 1'b0;
          AW'(3): mask_q <= bus_wdata[0];
          AW'(4): cfg_q <= bus_wdata;
          default: ;
        endcase
      end
      if (bus_we && in_buf) tx_q[{slot, 3'b000} +: 8] <= bus_wdata[7:0];
      if (!busy_q) sck_q <= cfg_q[5];
      if (go) begin
        busy_q <= 1'b1; trail_q <= 1'b0; div_q <= '0; e_q <= '0; obit_q <= '0;
        n_q <= n_eff; mt_q <= typ_q; cpha_q <= cfg_q[4]; half_q <= half_sel;
        id_q <= bus_wdata[8 +: IW]; tail_q <= '0;
      end else if (busy_q) begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick && trail_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          tail_q <= (mt_q == T_WR) ? '0 : n_q;
        end else if (tick) begin
          sck_q <= ~sck_q;
          if (samp) begin
            if (mt_q != T_WR) rx_q[bi ^ XW'(7)] <= miso;
          end else obit_q <= cpha_q ? bi : bi + 1'b1;
          if (last) trail_q <= 1'b1;
          else e_q <= e_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_msg_chk.sv
module spi_msg_chk #(
  parameter int NCS = 4,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] cs_n,
  input logic           sck,
  input logic           mosi,
  input logic           busy,
  input logic           done,
  input logic           cpol_cfg,
  input logic [1:0]     mtype,
  input logic [CW-1:0]  tail
);
  // R3: never more than one device selected
  p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  // R5: sck rests at the programmed polarity while idle
  p_idle_sck_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n && $past(&cs_n)) |-> sck == $past(cpol_cfg));
  // R9: done is set exactly when the select is released
  p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(&cs_n) |-> done);
  p_done_only_end_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $rose(&cs_n));
  // R8: half-duplex read keeps mosi low
  p_hdr_mosi_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && mtype == 2'd2) |-> !mosi);
  // R10: select holds steady through a running message
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n));
  // R7: half-duplex write reports no received bytes
  p_tail_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(&cs_n) && mtype == 2'd1) |-> tail == '0);
endmodule

bind spi_msg_master spi_msg_chk #(.NCS(NCS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .busy(busy_q),
  .done(done_q), .cpol_cfg(cfg_q[5]), .mtype(mt_q), .tail(tail_q)
);

// File: tb/sim_spi_msg_master.sv
`timescale 1ns/100ps
module sim_spi_msg_master;
  localparam int DEPTH = 8;
  localparam int NCS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        miso = 1'b0;
  wire [15:0]  rdata;
  wire         sck, mosi, irq;
  wire [NCS-1:0] cs_n;

  spi_msg_master #(.DEPTH(DEPTH), .NCS(NCS), .BASE_HALF(1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq));

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1'b1; addr = a[3:0]; wdata = d[15:0];
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); addr = a[3:0]; #1; d = int'(rdata);
  endtask

  // loopback slave model
  logic sl_cpol = 1'b0, sl_cpha = 1'b0;
  logic [63:0] sl_tx = '0, sl_rx = '0;
  int scnt = 0;
  logic sck_p = 1'b0, act_p = 1'b0;
  wire act = ~&cs_n;
  always @(sck or act) begin
    if (act && !act_p) begin
      scnt = 0; sl_rx = '0;
      miso = sl_cpha ? 1'b0 : sl_tx[7];
    end else if (act && sck != sck_p) begin
      if ((sck != sl_cpol) ^ sl_cpha) begin
        sl_rx[(scnt ^ 7) & 63] = mosi;
        scnt++;
      end else miso = sl_tx[(scnt ^ 7) & 63];
    end
    act_p = act; sck_p = sck;
  end

  logic [7:0] exp_rx [DEPTH];

  task automatic run(input int mode, input int typ, input int nfield, input int code,
                     input int dev, input bit msk, input int seed);
    int neff, half, dur, cyc, first, d;
    logic [7:0] txb [DEPTH];
    logic [7:0] slb [DEPTH];
    neff = (nfield > DEPTH) ? DEPTH : nfield;
    half = 1 << ((code == 7) ? 0 : 6 - code);
    dur  = half * (16 * neff + 1);
    sl_cpol = mode[1]; sl_cpha = mode[0];
    wr(4, 16'h9A40 | (mode << 4) | code);
    wr(3, int'(msk));
    for (int k = 0; k < DEPTH; k++) begin
      txb[k] = 8'(seed * 37 + k * 13 + 90);
      slb[k] = ~txb[k] ^ 8'(seed);
      sl_tx[8*k +: 8] = slb[k];
      wr(8 + k, int'(txb[k]));
    end
    wr(0, (typ << 8) | nfield);
    wr(1, (dev << 8) | 2);
    chk(cs_n == ~(4'b0001 << dev), "R3 select", int'(cs_n), int'(~(4'b0001 << dev)));
    cyc = 0; first = -1;
    while (cs_n != '1 && cyc < 20000) begin
      if (first < 0 && sck != mode[1]) first = cyc;
      cyc++;
      @(negedge clk);
    end
    chk(cyc == dur, "R4 select window", cyc, dur);
    chk(first == half, "R4 first edge", first, half);
    chk(sck == mode[1], "R5 idle sck", int'(sck), mode[1]);
    for (int k = 0; k < neff; k++) begin
      d = (typ == 2) ? 0 : int'(txb[k]);
      chk(sl_rx[8*k +: 8] == d[7:0], (typ == 2) ? "R8 mosi low" : "R5 slave byte",
          int'(sl_rx[8*k +: 8]), d);
    end
    rd(5, d);
    chk(d == ((typ == 1) ? 0 : neff), (typ == 1) ? "R7 tail" : "R6 tail", d, (typ == 1) ? 0 : neff);
    if (typ != 1) for (int k = 0; k < neff; k++) exp_rx[k] = slb[k];
    for (int k = 0; k < DEPTH; k++) begin
      rd(8 + k, d);
      chk(d == int'(exp_rx[k]), (typ == 1) ? "R7 rx kept" : "R6 rx byte", d, int'(exp_rx[k]));
    end
    rd(2, d);
    chk(d == 1, "R9 done", d, 1);
    chk(irq == msk, "R9 irq mask", int'(irq), int'(msk));
    wr(2, 1);
    rd(2, d);
    chk(d == 0 && irq == 1'b0, "R9 clear", d, 0);
  endtask

  initial begin
    int d, seed, cyc;
    bit held;
    for (int k = 0; k < DEPTH; k++) exp_rx[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(cs_n == '1 && sck == 1'b0 && mosi == 1'b0 && irq == 1'b0, "R1 pins",
        int'({cs_n, sck, mosi, irq}), 'h78);
    for (int a = 2; a <= 6; a++) begin
      rd(a, d);
      chk(d == 0, "R1 register", d, 0);
    end
    // R2 readback
    wr(4, 16'h9A75);
    rd(4, d);
    chk(d == 'h9A75, "R2 readback", d, 'h9A75);
    // R3 bad opcode and zero count
    wr(0, 3); wr(1, 16'h0105);
    chk(cs_n == '1, "R3 bad opcode", int'(cs_n), 'hF);
    wr(0, 0); wr(1, 16'h0202);
    rd(6, d);
    chk(cs_n == '1 && d == 0, "R3 zero count", d, 0);
    // sweep of modes, types and lengths
    seed = 1;
    for (int m = 0; m < 4; m++)
      for (int t = 0; t < 3; t++)
        for (int n = 1; n <= DEPTH; n++) begin
          run(m, t, n, 6, (n + t) % 4, n[0], seed);
          seed++;
        end
    // R6 reserved type, R11 clamp
    run(1, 3, 4, 5, 2, 1'b1, seed); seed++;
    run(2, 0, 15, 6, 1, 1'b1, seed); seed++;
    // R2 rate codes
    for (int c = 0; c < 8; c++) begin
      run(0, 0, 1, c, c % 4, 1'b0, seed);
      seed++;
    end
    // R10 start while busy
    wr(4, 16'h0004); wr(0, 2); wr(1, 16'h0002);
    cyc = 0; held = 1'b1;
    while (cs_n != '1 && cyc < 20000) begin
      if (cs_n != 4'b1110) held = 1'b0;
      if (cyc == 5) begin we = 1'b1; addr = 4'd1; wdata = 16'h0302; end
      if (cyc == 6) we = 1'b0;
      cyc++;
      @(negedge clk);
    end
    chk(held, "R10 select held", int'(held), 1);
    chk(cyc == 4 * 33, "R10 length kept", cyc, 4 * 33);
    wr(2, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule